// File: doc/BRIEF.md
# Reservation Monitor for Load-Linked / Store-Conditional Atomics

This block gives several hardware contexts shared access to a small word memory and supports lock-free read-modify-write sequences built from a linked load and a conditional store. A linked load returns the addressed word. It also leaves a reservation for the issuing context, made of a valid bit and a word address. The matching conditional store does not write blindly. It writes only if that reservation has survived, and it answers with a one-bit flag that the requester places in its destination register. Software loops on the flag until it reads 1.

Nothing is locked or stalled when a linked load is issued. Any other context keeps reading and writing freely, and the outcome is decided only at the conditional store. When several contexts issue requests in the same cycle, the block treats them as if they happened one after another in ascending context index. It uses that order to decide which reservations break, which conditional stores succeed, and which data ends up in memory. Read data always reflects the memory as it was at the start of the cycle.

Top module: `rsv_atomic_mem`

## Requirements
- R1: After reset every word of the memory reads 0, no context holds a reservation, `rsp_valid` is low, and `req_ready` is low until the first clock edge after reset is released. From then on `req_ready` is high.
- R2: A request is accepted when `req_valid` and `req_ready` are both high for its context. `rsp_valid` of that context is high in the next cycle and low after a cycle with no accepted request. The op codes on `req_op` are 00 plain load, 01 plain store, 10 linked load and 11 conditional store.
- R3: A plain load or a linked load returns the word held at the address before any write of the same cycle. A plain store writes its data and returns 0.
- R4: A linked load records a reservation on its address. A later conditional store by the same context to that address, with the reservation intact, writes its data and returns 1 in bit 0 with all other bits 0.
- R5: A conditional store from a context with no valid reservation returns 0 and leaves memory unchanged.
- R6: A conditional store to an address other than the reserved one returns 0 and leaves memory unchanged.
- R7: A plain store or a successful conditional store by another context to the reserved address breaks the reservation. Writes to other addresses, and plain stores by the reserving context itself, leave the reservation intact.
- R8: A new linked load replaces the context's earlier reservation, so the old address no longer qualifies.
- R9: A conditional store clears its own context's reservation, whether it succeeds or fails.
- R10: When conditional stores from several contexts target the same reserved address in one cycle, at most one succeeds, and it is the lowest-index context that qualifies. A linked load made in a cycle where another context writes the same address returns the old word, and its reservation starts broken.
- R11: When several writes target one address in the same cycle, the highest-index writer's data is what remains in memory. A plain store by a lower-index context in the same cycle makes a higher-index conditional store to that address fail.
- R12: A held reservation never blocks anything. `req_ready` stays high, and other contexts are served every cycle while the reservation is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | N_CTX | Per-context request valid |
| req_ready | output | N_CTX | Per-context request ready |
| req_op | input | 2*N_CTX | Per-context op code, 2 bits each |
| req_addr | input | N_CTX*ADDR_W | Per-context word address |
| req_wdata | input | N_CTX*DATA_W | Per-context store data |
| rsp_valid | output | N_CTX | Per-context response valid, one cycle after acceptance |
| rsp_data | output | N_CTX*DATA_W | Read word, success flag in bit 0, or 0 for a plain store |

## Verification
The first sweep pairs every context with every other context as the possible breaker. Each pair is tried with the breaking write on the reserved word and on a neighbouring word. This separates a real break from address aliasing, and it separates a break by another context from a harmless store by the reserving context itself. Directed sequences cover several more cases:
- A conditional store with no reservation, with a stale reservation and with a replaced reservation, which separates R5, R8 and R9.
- Same-cycle collisions of conditional stores, plain stores and linked loads, which expose the ordering rules of R10 and R11.

A long stretch of mixed random traffic on four shared words is then checked against an arithmetic model of the ordering rule.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_LINK  = 2'b10,
    OP_COND  = 2'b11
  } rsv_op_e;
endpackage

// File: rtl/rsv_ctx_slot.sv
module rsv_ctx_slot #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic              set_vld,
  input  logic              clr_en,
  input  logic              brk,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              vld_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic              vld_q, vld_n;
  logic [ADDR_W-1:0] addr_q, addr_n;

  always_comb begin
    vld_n  = vld_q;
    addr_n = addr_q;
    if (set_en) begin
      vld_n  = set_vld;
      addr_n = addr_in;
    end else if (clr_en || brk) begin
      vld_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      vld_q  <= vld_n;
      addr_q <= addr_n;
    end
  end

  assign vld_o  = vld_q;
  assign addr_o = addr_q;

  // R9: a conditional store always leaves its slot empty
  assert_cond_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en) |=> !vld_o);

  // R8: a linked load overwrites the held address
  assert_link_replaces_R8: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> (addr_o == $past(addr_in)));
endmodule

// File: rtl/rsv_word_array.sv
module rsv_word_array #(
  parameter int N_CTX  = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_CTX-1:0]          we,
  input  logic [N_CTX*ADDR_W-1:0]   waddr,
  input  logic [N_CTX*DATA_W-1:0]   wdata,
  input  logic [N_CTX*ADDR_W-1:0]   raddr,
  output logic [N_CTX*DATA_W-1:0]   rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] mem_n [DEPTH];

  // writes applied in ascending index: the highest index lands last
  always_comb begin
    for (int k = 0; k < DEPTH; k++) mem_n[k] = mem_q[k];
    for (int i = 0; i < N_CTX; i++) begin
      if (we[i]) mem_n[waddr[i*ADDR_W +: ADDR_W]] = wdata[i*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) mem_q[k] <= '0;
    end else begin
      for (int k = 0; k < DEPTH; k++) mem_q[k] <= mem_n[k];
    end
  end

  for (genvar g = 0; g < N_CTX; g++) begin : g_rd
    assign rdata[g*DATA_W +: DATA_W] = mem_q[raddr[g*ADDR_W +: ADDR_W]];
  end

  // R11: the top-index writer's data is what survives
  assert_top_writer_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    we[N_CTX-1] |=> (mem_q[$past(waddr[(N_CTX-1)*ADDR_W +: ADDR_W])]
                     == $past(wdata[(N_CTX-1)*DATA_W +: DATA_W])));
endmodule

// File: rtl/rsv_atomic_mem.sv
module rsv_atomic_mem
  import rsv_pkg::*;
#(
  parameter int N_CTX  = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_CTX-1:0]        req_valid,
  output logic [N_CTX-1:0]        req_ready,
  input  logic [2*N_CTX-1:0]      req_op,
  input  logic [N_CTX*ADDR_W-1:0] req_addr,
  input  logic [N_CTX*DATA_W-1:0] req_wdata,
  output logic [N_CTX-1:0]        rsp_valid,
  output logic [N_CTX*DATA_W-1:0] rsp_data
);
  logic                    ready_q;
  logic [N_CTX-1:0]        acc;
  rsv_op_e                 op_a   [N_CTX];
  logic [ADDR_W-1:0]       addr_a [N_CTX];
  logic [N_CTX-1:0]        slot_vld;
  logic [ADDR_W-1:0]       slot_addr [N_CTX];
  logic [N_CTX-1:0]        wr_en, cond_ok, lose_rsv, link_hit;
  logic [N_CTX*DATA_W-1:0] rd_word;
  logic [N_CTX-1:0]        rsp_vld_q;
  logic [DATA_W-1:0]       rsp_d_q [N_CTX];
  logic [DATA_W-1:0]       rsp_d_n [N_CTX];

  assign req_ready = {N_CTX{ready_q}};
  assign acc       = req_valid & req_ready;

  for (genvar g = 0; g < N_CTX; g++) begin : g_unpack
    assign op_a[g]   = rsv_op_e'(req_op[2*g +: 2]);
    assign addr_a[g] = req_addr[g*ADDR_W +: ADDR_W];
  end

  // serialize same-cycle requests in ascending context order
  always_comb begin
    logic [N_CTX-1:0] wr_v;
    logic [N_CTX-1:0] ok_v;
    wr_v = '0;
    ok_v = '0;
    for (int i = 0; i < N_CTX; i++) begin
      if (acc[i] && op_a[i] == OP_STORE) begin
        wr_v[i] = 1'b1;
      end else if (acc[i] && op_a[i] == OP_COND) begin
        ok_v[i] = slot_vld[i] && (slot_addr[i] == addr_a[i]);
        for (int j = 0; j < i; j++) begin
          if (wr_v[j] && addr_a[j] == addr_a[i]) ok_v[i] = 1'b0;
        end
        wr_v[i] = ok_v[i];
      end
    end
    wr_en   = wr_v;
    cond_ok = ok_v;
  end

  // snoop writes of the other contexts against held and fresh reservations
  always_comb begin
    lose_rsv = '0;
    link_hit = '0;
    for (int i = 0; i < N_CTX; i++) begin
      for (int j = 0; j < N_CTX; j++) begin
        if (j != i && wr_en[j]) begin
          if (addr_a[j] == slot_addr[i]) lose_rsv[i] = 1'b1;
          if (addr_a[j] == addr_a[i])    link_hit[i] = 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < N_CTX; g++) begin : g_slot
    rsv_ctx_slot #(.ADDR_W(ADDR_W)) slot_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (acc[g] && op_a[g] == OP_LINK),
      .set_vld (!link_hit[g]),
      .clr_en  (acc[g] && op_a[g] == OP_COND),
      .brk     (lose_rsv[g]),
      .addr_in (addr_a[g]),
      .vld_o   (slot_vld[g]),
      .addr_o  (slot_addr[g])
    );
  end

  rsv_word_array #(.N_CTX(N_CTX), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) mem_i (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en),
    .waddr (req_addr),
    .wdata (req_wdata),
    .raddr (req_addr),
    .rdata (rd_word)
  );

  always_comb begin
    for (int i = 0; i < N_CTX; i++) begin
      rsp_d_n[i] = rsp_d_q[i];
      if (acc[i]) begin
        case (op_a[i])
          OP_LOAD, OP_LINK: rsp_d_n[i] = rd_word[i*DATA_W +: DATA_W];
          OP_STORE:         rsp_d_n[i] = '0;
          default:          rsp_d_n[i] = {{(DATA_W-1){1'b0}}, cond_ok[i]};
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q   <= 1'b0;
      rsp_vld_q <= '0;
      for (int i = 0; i < N_CTX; i++) rsp_d_q[i] <= '0;
    end else begin
      ready_q   <= 1'b1;
      rsp_vld_q <= acc;
      for (int i = 0; i < N_CTX; i++) rsp_d_q[i] <= rsp_d_n[i];
    end
  end

  assign rsp_valid = rsp_vld_q;
  for (genvar g = 0; g < N_CTX; g++) begin : g_pack
    assign rsp_data[g*DATA_W +: DATA_W] = rsp_d_q[g];
  end

  // R1: ready comes up one edge after reset release and stays up
  assert_ready_up_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (&req_ready));

  for (genvar g = 0; g < N_CTX; g++) begin : g_chk
    // R2: response exactly one cycle after acceptance
    assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      acc[g] |=> rsp_valid[g]);
    assert_rsp_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !acc[g] |=> !rsp_valid[g]);
    // R3: plain store answers with zero
    assert_store_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc[g] && op_a[g] == OP_STORE) |=> (rsp_data[g*DATA_W +: DATA_W] == '0));
    // R5: no reservation, no success
    assert_no_rsv_fails_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc[g] && op_a[g] == OP_COND && !slot_vld[g])
      |=> (rsp_data[g*DATA_W +: DATA_W] == '0));
    for (genvar h = g + 1; h < N_CTX; h++) begin : g_pair
      // R10: two same-address conditional stores never both succeed
      assert_single_winner_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc[g] && acc[h] && op_a[g] == OP_COND && op_a[h] == OP_COND
         && addr_a[g] == addr_a[h])
        |=> !(rsp_data[g*DATA_W] && rsp_data[h*DATA_W]));
    end
  end
endmodule

// File: tb/rsv_atomic_mem_tb_top.sv
`timescale 1ns/1ps
module rsv_atomic_mem_tb_top;
  import rsv_pkg::*;
  localparam int N = 4;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [N-1:0]    req_valid;
  logic [N-1:0]    req_ready;
  logic [2*N-1:0]  req_op;
  logic [N*AW-1:0] req_addr;
  logic [N*DW-1:0] req_wdata;
  logic [N-1:0]    rsp_valid;
  logic [N*DW-1:0] rsp_data;

  always #4 clk = ~clk;

  rsv_atomic_mem #(.N_CTX(N), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [DW-1:0] m_mem [DEPTH];
  logic          m_rv  [N];
  logic [AW-1:0] m_ra  [N];
  logic          b_vld [N];
  logic [1:0]    b_op  [N];
  logic [AW-1:0] b_addr[N];
  logic [DW-1:0] b_wd  [N];

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic put(input int c, input logic [1:0] op, input int a, input int d);
    b_vld[c]  = 1'b1;
    b_op[c]   = op;
    b_addr[c] = AW'(a);
    b_wd[c]   = DW'(d);
  endtask

  // one request cycle: drive, predict from the serialized-order rule, check
  task automatic step(input string tag);
    logic [DW-1:0] ed [N];
    logic          w  [N];
    logic          nrv[N];
    for (int i = 0; i < N; i++) begin
      req_valid[i]           = b_vld[i];
      req_op[2*i +: 2]       = b_op[i];
      req_addr[i*AW +: AW]   = b_addr[i];
      req_wdata[i*DW +: DW]  = b_wd[i];
      ed[i] = '0;
      w[i]  = 1'b0;
    end
    for (int i = 0; i < N; i++) begin
      if (b_vld[i]) begin
        if (b_op[i] == OP_LOAD || b_op[i] == OP_LINK) ed[i] = m_mem[b_addr[i]];
        else if (b_op[i] == OP_STORE) w[i] = 1'b1;
        else begin
          logic ok;
          ok = m_rv[i] && (m_ra[i] == b_addr[i]);
          for (int j = 0; j < i; j++) if (w[j] && b_addr[j] == b_addr[i]) ok = 1'b0;
          w[i]  = ok;
          ed[i] = DW'(ok);
        end
      end
    end
    for (int i = 0; i < N; i++) begin
      logic brk, hit;
      brk = 1'b0;
      hit = 1'b0;
      for (int j = 0; j < N; j++) begin
        if (j != i && w[j] && b_addr[j] == m_ra[i])   brk = 1'b1;
        if (j != i && w[j] && b_addr[j] == b_addr[i]) hit = 1'b1;
      end
      if (b_vld[i] && b_op[i] == OP_LINK) nrv[i] = !hit;
      else if (b_vld[i] && b_op[i] == OP_COND) nrv[i] = 1'b0;
      else if (brk) nrv[i] = 1'b0;
      else nrv[i] = m_rv[i];
    end
    @(posedge clk);
    @(negedge clk);
    check("R12", "ready", 32'(req_ready), 32'({N{1'b1}}));
    for (int i = 0; i < N; i++) begin
      check("R2", $sformatf("rsp_valid ctx%0d", i), 32'(rsp_valid[i]), 32'(b_vld[i]));
      if (b_vld[i])
        check(tag, $sformatf("rsp_data ctx%0d", i), 32'(rsp_data[i*DW +: DW]), 32'(ed[i]));
    end
    for (int i = 0; i < N; i++) begin
      if (b_vld[i] && b_op[i] == OP_LINK) m_ra[i] = b_addr[i];
      m_rv[i] = nrv[i];
      if (w[i]) m_mem[b_addr[i]] = b_wd[i];
      b_vld[i] = 1'b0;
    end
    req_valid = '0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R2: actual hung expected finish");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = '0; req_op = '0; req_addr = '0; req_wdata = '0;
    for (int k = 0; k < DEPTH; k++) m_mem[k] = '0;
    for (int i = 0; i < N; i++) begin
      m_rv[i] = 1'b0; m_ra[i] = '0;
      b_vld[i] = 1'b0; b_op[i] = '0; b_addr[i] = '0; b_wd[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", "ready before first edge", 32'(req_ready), 32'(0));
    check("R1", "rsp_valid after reset", 32'(rsp_valid), 32'(0));
    @(negedge clk);
    check("R1", "ready after first edge", 32'(req_ready), 32'({N{1'b1}}));

    // R1: every word starts at zero
    for (int a = 0; a < DEPTH; a++) begin put(a % N, OP_LOAD, a, 0); step("R1"); end
    // R5: nobody holds a reservation yet
    for (int c = 0; c < N; c++) begin put(c, OP_COND, c, 8'hEE); step("R5"); end
    // R3: store sweep then read back
    for (int a = 0; a < DEPTH; a++) begin put(a % N, OP_STORE, a, a * 7 + 3); step("R3"); end
    for (int a = 0; a < DEPTH; a++) begin put((a + 1) % N, OP_LOAD, a, 0); step("R3"); end

    // R4 / R7: each reserver against each breaker, on and off the reserved word
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        for (int s = 0; s < 2; s++) begin
          int a;
          a = (i * N + j) % DEPTH;
          put(i, OP_LINK, a, 0);                           step("R4");
          put(j, OP_STORE, (s == 0) ? a : (a ^ 1), 8'h40 + j); step("R7");
          put(i, OP_COND, a, 8'hA0 + i);                   step("R7");
          put(i, OP_LOAD, a, 0);                           step("R4");
        end

    // R9: success then retry without a new link fails
    put(1, OP_LINK, 5, 0); step("R4");
    put(1, OP_COND, 5, 8'h11); step("R4");
    put(1, OP_COND, 5, 8'h22); step("R9");
    put(1, OP_LOAD, 5, 0); step("R9");
    // R9: a failing conditional store also empties the slot
    put(2, OP_LINK, 6, 0); step("R4");
    put(2, OP_COND, 7, 8'h33); step("R6");
    put(2, OP_COND, 6, 8'h34); step("R9");
    put(2, OP_LOAD, 6, 0); step("R9");
    // R6: wrong address does not write
    put(3, OP_LINK, 8, 0); step("R4");
    put(3, OP_COND, 9, 8'h55); step("R6");
    put(3, OP_LOAD, 9, 0); step("R6");
    // R8: replacement
    put(0, OP_LINK, 10, 0); step("R8");
    put(0, OP_LINK, 11, 0); step("R8");
    put(0, OP_COND, 10, 8'h66); step("R8");
    put(0, OP_LINK, 10, 0); step("R8");
    put(0, OP_LINK, 11, 0); step("R8");
    put(0, OP_COND, 11, 8'h67); step("R8");

    // R10: simultaneous conditional stores, lowest qualifying index wins
    for (int c = 0; c < N; c++) put(c, OP_LINK, 12, 0);
    step("R10");
    for (int c = 0; c < N; c++) put(c, OP_COND, 12, 8'h70 + c);
    step("R10");
    put(3, OP_LINK, 12, 0); put(1, OP_COND, 12, 8'h79); step("R10");
    put(1, OP_COND, 12, 8'h7A); put(3, OP_COND, 12, 8'h7B); step("R10");
    put(0, OP_LOAD, 12, 0); step("R10");
    // R10: link in the same cycle as another context's write starts broken
    put(2, OP_LINK, 13, 0); put(0, OP_STORE, 13, 8'h81); step("R10");
    put(2, OP_COND, 13, 8'h82); step("R10");
    put(2, OP_LINK, 13, 0); put(3, OP_STORE, 13, 8'h83); step("R10");
    put(2, OP_COND, 13, 8'h84); step("R10");

    // R11: colliding stores and store-before-conditional
    for (int c = 0; c < N; c++) put(c, OP_STORE, 14, 8'h90 + c);
    step("R11");
    put(0, OP_LOAD, 14, 0); step("R11");
    put(1, OP_LINK, 15, 0); step("R4");
    put(0, OP_STORE, 15, 8'hA5); put(1, OP_COND, 15, 8'hA6); step("R11");
    put(2, OP_LOAD, 15, 0); step("R11");

    // R12: reservation held while others keep working
    put(0, OP_LINK, 3, 0); step("R12");
    for (int k = 0; k < 6; k++) begin
      put(1, OP_STORE, 4 + k, k); put(2, OP_LOAD, 3, 0); put(3, OP_LOAD, k, 0);
      step("R12");
    end
    put(0, OP_COND, 3, 8'hC3); step("R12");

    // mixed traffic on four shared words
    for (int n = 0; n < 2000; n++) begin
      for (int c = 0; c < N; c++)
        if ($urandom_range(0, 2) != 0)
          put(c, 2'($urandom_range(0, 3)), $urandom_range(0, 3), $urandom_range(0, 255));
      step("R7");
    end
    finish_run();
  end
endmodule